// File: doc/BRIEF.md
# Byte-Level I2C Master Register Controller

This block is the software-facing half of an I2C master. A processor reaches six byte-wide registers (own slave address, clock divider setting, control, status, data, input filter setting) through a single-cycle register port. Writes and reads of the data register are turned into byte-level requests on a simple bus port: open a transfer with an address byte, send a byte, fetch a byte, or close the transfer. A separate engine carries out the wire-level signalling and answers each request with an acknowledge flag and, for fetches, a data byte.

The controller tracks whether a transfer is open. While none is open, the next data write becomes the address byte, and while one is open, data writes are payload. In master receive mode, each read of the data register returns the byte already held and starts fetching the next one. Clearing the enable bit performs a soft reset that keeps the own-address register. Setting the repeated-start bit while a transfer is open closes it so that the next data write re-addresses. A level interrupt reports completed bytes.

Top module: `i2c_master_regs`

## Requirements
- R1: After reset the status register reads 0x81, every other register reads 0x00, no transfer is open and `irq` is low.
- R2: Registers sit at byte offsets own address 0x00, divider 0x04, control 0x08, status 0x0C, data 0x10, filter 0x14. A read of any other offset returns 0x00.
- R3: Written values are masked with 0xFE (own address), 0x3F (divider), 0xFC (control) and 0xED (status). The filter register keeps all 8 bits.
- R4: A data-register write while control bit 7 (enable) is clear changes nothing and issues no bus request.
- R5: A control write with bit 5 (master) set sets status bit 5 (bus busy). With bit 5 clear, it clears status bit 5, and if a transfer is open it issues an end request (op 3) and closes the transfer.
- R6: With enable and master set, a data write issues a start request (op 0) carrying the written byte when no transfer is open, and a send request (op 1) otherwise.
- R7: An acknowledged start or send clears status bit 0 and sets status bits 7 (done) and 1 (flag), and an acknowledged start opens the transfer. A refused start sets only status bit 0 and leaves the transfer closed.
- R8: A refused send sets status bit 0 and issues an end request (op 3) without setting bits 7 or 1.
- R9: `irq` is high exactly when control bit 7, control bit 6 (interrupt enable) and status bit 1 are all set. Writing status bit 1 to 0 lowers it.
- R10: A control write with bit 2 (repeated start) set, master set and a transfer open issues an end request, closes the transfer and stores bit 2 as 0. The next data write issues a start.
- R11: A data read with master set and control bit 4 (transmit) clear returns the byte held before the read and issues a fetch request (op 2). An acknowledged fetch loads the received byte and sets status bits 7 and 1. A refused fetch loads 0xFF and leaves those bits unchanged. With master clear, a data read issues no request.
- R12: A control write that clears bit 7 while it is set restores every register to its reset value except the own address, and closes the transfer. The written value is not otherwise stored.
- R13: At most one bus request is outstanding. `bus_req_valid` and its op and byte stay stable until `bus_req_ready`, and `cpu_ready` is low from the issue of a request until its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Register access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte offset of the register |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid the cycle after an accepted read |
| cpu_ready | output | 1 | Access accepted at this edge when high |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_ready | input | 1 | Engine takes the request |
| bus_req_op | output | 2 | 0 start, 1 send, 2 fetch, 3 end |
| bus_req_byte | output | 8 | Address byte or data byte to send |
| bus_rsp_valid | input | 1 | One-cycle response pulse |
| bus_rsp_ack | input | 1 | Request acknowledged |
| bus_rsp_byte | input | 8 | Fetched byte |
| irq | output | 1 | Level interrupt |

## Verification
A stale transfer-open state shows up at the very next data write, which carries the wrong op code (start instead of send, or the reverse), or at a control write that issues an extra end request or fails to issue one. A wrong status update is visible in the first status read after the response, and on `irq` one cycle after the response pulse. The bench counts bus requests by op and compares op, byte, status and data reads after each access, so a fault shows up within one register transaction.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int NREG       = 6;
  localparam int REG_STRIDE = 4;
  localparam int IX_OWN = 0;
  localparam int IX_DIV = 1;
  localparam int IX_CTL = 2;
  localparam int IX_STA = 3;
  localparam int IX_DAT = 4;
  localparam int IX_FLT = 5;

  localparam int C_EN = 7;
  localparam int C_IE = 6;
  localparam int C_MS = 5;
  localparam int C_TX = 4;
  localparam int C_RS = 2;
  localparam int S_DONE = 7;
  localparam int S_BUSY = 5;
  localparam int S_FLAG = 1;
  localparam int S_NACK = 0;

  localparam logic [7:0] M_OWN   = 8'hFE;
  localparam logic [7:0] M_DIV   = 8'h3F;
  localparam logic [7:0] M_CTL   = 8'hFC;
  localparam logic [7:0] M_STA   = 8'hED;
  localparam logic [7:0] STA_RST = 8'h81;
  localparam logic [7:0] TGT_NONE = 8'hFF;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_END   = 2'd3
  } bus_op_e;
endpackage

// File: rtl/i2cm_decode.sv
module i2cm_decode import i2cm_pkg::*; #(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit
);
  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i] = (addr == ADDR_W'(i * REG_STRIDE));
  end
endmodule

// File: rtl/i2cm_rd_mux.sv
module i2cm_rd_mux import i2cm_pkg::*; (
  input  logic [NREG-1:0]      hit,
  input  logic [NREG-1:0][7:0] regs,
  output logic [7:0]           value
);
  logic [NREG-1:0][7:0] term;

  for (genvar i = 0; i < NREG; i++) begin : g_term
    assign term[i] = {8{hit[i]}} & regs[i];
  end

  always_comb begin
    value = 8'h00;
    for (int i = 0; i < NREG; i++) value = value | term[i];
  end
endmodule

// File: rtl/i2cm_bus_port.sv
module i2cm_bus_port import i2cm_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       issue,
  input  bus_op_e    issue_op,
  input  logic [7:0] issue_byte,
  output logic       busy,
  output logic       done,
  output bus_op_e    done_op,
  output logic       done_ack,
  output logic [7:0] done_byte,
  output logic       bus_req_valid,
  input  logic       bus_req_ready,
  output logic [1:0] bus_req_op,
  output logic [7:0] bus_req_byte,
  input  logic       bus_rsp_valid,
  input  logic       bus_rsp_ack,
  input  logic [7:0] bus_rsp_byte
);
  typedef enum logic [1:0] {P_IDLE, P_REQ, P_WAIT} port_st_e;

  port_st_e   st_q;
  bus_op_e    op_q;
  logic [7:0] byte_q;
  logic       vld_q;

  assign done      = (st_q == P_WAIT) && bus_rsp_valid;
  assign done_op   = op_q;
  assign done_ack  = bus_rsp_ack;
  assign done_byte = bus_rsp_byte;
  assign busy      = (st_q != P_IDLE);

  assign bus_req_valid = vld_q;
  assign bus_req_op    = op_q;
  assign bus_req_byte  = byte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= P_IDLE;
      op_q   <= OP_START;
      byte_q <= 8'h00;
      vld_q  <= 1'b0;
    end else begin
      unique case (st_q)
        P_IDLE: if (issue) begin
          st_q   <= P_REQ;
          vld_q  <= 1'b1;
          op_q   <= issue_op;
          byte_q <= issue_byte;
        end
        P_REQ: if (bus_req_ready) begin
          st_q  <= P_WAIT;
          vld_q <= 1'b0;
        end
        P_WAIT: if (bus_rsp_valid) begin
          if (issue) begin
            st_q   <= P_REQ;
            vld_q  <= 1'b1;
            op_q   <= issue_op;
            byte_q <= issue_byte;
          end else begin
            st_q <= P_IDLE;
          end
        end
        default: st_q <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_master_regs.sv
module i2c_master_regs import i2cm_pkg::*; #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_sel,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              cpu_ready,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [1:0]        bus_req_op,
  output logic [7:0]        bus_req_byte,
  input  logic              bus_rsp_valid,
  input  logic              bus_rsp_ack,
  input  logic [7:0]        bus_rsp_byte,
  output logic              irq
);
  logic [7:0] own_q, div_q, ctl_q, sta_q, dat_q, flt_q, tgt_q;
  logic [7:0] own_d, div_d, ctl_d, sta_d, dat_d, flt_d, tgt_d;
  logic       irq_q, irq_d;
  logic [7:0] rdata_q, rd_val;

  logic [NREG-1:0]      hit;
  logic [NREG-1:0][7:0] regs;

  logic       busy, done, done_ack;
  bus_op_e    done_op;
  logic [7:0] done_byte;
  logic       issue;
  bus_op_e    issue_op;
  logic [7:0] issue_byte;

  logic accept, wr, rd, open_xfer;

  i2cm_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(cpu_addr), .hit(hit));

  assign regs[IX_OWN] = own_q;
  assign regs[IX_DIV] = div_q;
  assign regs[IX_CTL] = ctl_q;
  assign regs[IX_STA] = sta_q;
  assign regs[IX_DAT] = dat_q;
  assign regs[IX_FLT] = flt_q;

  i2cm_rd_mux u_mux (.hit(hit), .regs(regs), .value(rd_val));

  i2cm_bus_port u_port (
    .clk(clk), .rst(rst),
    .issue(issue), .issue_op(issue_op), .issue_byte(issue_byte),
    .busy(busy), .done(done), .done_op(done_op),
    .done_ack(done_ack), .done_byte(done_byte),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_op(bus_req_op), .bus_req_byte(bus_req_byte),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_ack(bus_rsp_ack),
    .bus_rsp_byte(bus_rsp_byte)
  );

  assign cpu_ready = !busy;
  assign accept    = cpu_sel && !busy;
  assign wr        = accept && cpu_we;
  assign rd        = accept && !cpu_we;
  assign open_xfer = (tgt_q != TGT_NONE);

  always_comb begin
    own_d = own_q; div_d = div_q; ctl_d = ctl_q; sta_d = sta_q;
    dat_d = dat_q; flt_d = flt_q; tgt_d = tgt_q;
    issue = 1'b0; issue_op = OP_START; issue_byte = 8'h00;

    if (done) begin
      unique case (done_op)
        OP_START, OP_SEND: begin
          if (done_ack) begin
            if (done_op == OP_START) tgt_d = dat_q;
            sta_d[S_NACK] = 1'b0;
            sta_d[S_DONE] = 1'b1;
            sta_d[S_FLAG] = 1'b1;
          end else begin
            sta_d[S_NACK] = 1'b1;
            if (done_op == OP_SEND) begin
              issue    = 1'b1;
              issue_op = OP_END;
            end
          end
        end
        OP_RECV: begin
          if (done_ack) begin
            dat_d         = done_byte;
            sta_d[S_DONE] = 1'b1;
            sta_d[S_FLAG] = 1'b1;
          end else begin
            dat_d = 8'hFF;
          end
        end
        default: ;
      endcase
    end else if (wr) begin
      if (hit[IX_OWN]) own_d = cpu_wdata & M_OWN;
      if (hit[IX_DIV]) div_d = cpu_wdata & M_DIV;
      if (hit[IX_FLT]) flt_d = cpu_wdata;
      if (hit[IX_STA]) sta_d = cpu_wdata & M_STA;
      if (hit[IX_CTL]) begin
        if (ctl_q[C_EN] && !cpu_wdata[C_EN]) begin
          div_d = 8'h00; ctl_d = 8'h00; sta_d = STA_RST;
          dat_d = 8'h00; flt_d = 8'h00; tgt_d = TGT_NONE;
        end else begin
          ctl_d = cpu_wdata & M_CTL;
          if (cpu_wdata[C_MS]) begin
            sta_d[S_BUSY] = 1'b1;
          end else begin
            sta_d[S_BUSY] = 1'b0;
            if (open_xfer) begin
              issue    = 1'b1;
              issue_op = OP_END;
              tgt_d    = TGT_NONE;
            end
          end
          if (cpu_wdata[C_RS] && (tgt_d != TGT_NONE)) begin
            issue       = 1'b1;
            issue_op    = OP_END;
            tgt_d       = TGT_NONE;
            ctl_d[C_RS] = 1'b0;
          end
        end
      end
      if (hit[IX_DAT] && ctl_q[C_EN]) begin
        dat_d = cpu_wdata;
        if (ctl_q[C_MS]) begin
          issue      = 1'b1;
          issue_op   = open_xfer ? OP_SEND : OP_START;
          issue_byte = cpu_wdata;
        end
      end
    end else if (rd && hit[IX_DAT] && ctl_q[C_MS] && !ctl_q[C_TX]) begin
      issue    = 1'b1;
      issue_op = OP_RECV;
    end

    irq_d = ctl_d[C_EN] && ctl_d[C_IE] && sta_d[S_FLAG];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q <= 8'h00; div_q <= 8'h00; ctl_q <= 8'h00; sta_q <= STA_RST;
      dat_q <= 8'h00; flt_q <= 8'h00; tgt_q <= TGT_NONE;
      irq_q <= 1'b0;  rdata_q <= 8'h00;
    end else begin
      own_q <= own_d; div_q <= div_d; ctl_q <= ctl_d; sta_q <= sta_d;
      dat_q <= dat_d; flt_q <= flt_d; tgt_q <= tgt_d;
      irq_q <= irq_d;
      if (rd) rdata_q <= rd_val;
    end
  end

  assign cpu_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker import i2cm_pkg::*; #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_sel,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              cpu_ready,
  input logic              bus_req_valid,
  input logic              bus_req_ready,
  input logic [1:0]        bus_req_op,
  input logic [7:0]        bus_req_byte,
  input logic              irq,
  input logic [7:0]        ctl_q,
  input logic [7:0]        sta_q,
  input logic [7:0]        dat_q
);
  logic wr_ok;
  assign wr_ok = cpu_sel && cpu_we && cpu_ready;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (sta_q == STA_RST) && !irq && !bus_req_valid);

  assert_sta_mask_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && cpu_addr == ADDR_W'(IX_STA * REG_STRIDE))
    |=> sta_q == ($past(cpu_wdata) & M_STA));

  assert_no_effect_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && cpu_addr == ADDR_W'(IX_DAT * REG_STRIDE) && !ctl_q[C_EN])
    |=> $stable(dat_q) && !bus_req_valid);

  assert_busy_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && cpu_addr == ADDR_W'(IX_CTL * REG_STRIDE) && !(ctl_q[C_EN] && !cpu_wdata[C_EN]))
    |=> sta_q[S_BUSY] == $past(cpu_wdata[C_MS]));

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (rst)
    irq == (ctl_q[C_EN] && ctl_q[C_IE] && sta_q[S_FLAG]));

  assert_soft_reset_R12: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && cpu_addr == ADDR_W'(IX_CTL * REG_STRIDE) && ctl_q[C_EN] && !cpu_wdata[C_EN])
    |=> (sta_q == STA_RST) && (ctl_q == 8'h00) && !irq);

  assert_req_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && !bus_req_ready)
    |=> bus_req_valid && $stable(bus_req_op) && $stable(bus_req_byte));

  assert_stall_R13: assert property (@(posedge clk) disable iff (rst)
    bus_req_valid |-> !cpu_ready);
endmodule

bind i2c_master_regs i2cm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
  .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
  .bus_req_op(bus_req_op), .bus_req_byte(bus_req_byte), .irq(irq),
  .ctl_q(ctl_q), .sta_q(sta_q), .dat_q(dat_q)
);

// File: tb/sim_i2c_master_regs.sv
`timescale 1ns/1ps
module sim_i2c_master_regs;
  localparam int AW = 5;
  localparam logic [4:0] A_OWN = 5'h00, A_DIV = 5'h04, A_CTL = 5'h08,
                         A_STA = 5'h0C, A_DAT = 5'h10, A_FLT = 5'h14;
  localparam logic [6:0] SLAVE = 7'h50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_sel = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic cpu_ready, bus_req_valid, irq;
  logic [1:0] bus_req_op;
  logic [7:0] bus_req_byte;
  logic tick = 1'b0;
  logic bus_rsp_valid = 1'b0, bus_rsp_ack = 1'b0;
  logic [7:0] bus_rsp_byte = 8'h00;

  always #5 clk = ~clk;

  i2c_master_regs #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .bus_req_valid(bus_req_valid),
    .bus_req_ready(tick), .bus_req_op(bus_req_op),
    .bus_req_byte(bus_req_byte), .bus_rsp_valid(bus_rsp_valid),
    .bus_rsp_ack(bus_rsp_ack), .bus_rsp_byte(bus_rsp_byte), .irq(irq)
  );

  // Bus engine model: one response per accepted request, a few cycles later
  logic pend = 1'b0;
  int   wait_cnt = 0;
  int   nops = 0, nend = 0;
  logic [1:0] last_op = 2'd0;
  logic [7:0] last_byte = 8'h00;
  logic [7:0] rcnt = 8'h30;
  logic recv_fail = 1'b0;

  always @(posedge clk) begin
    tick <= ~tick;
    bus_rsp_valid <= 1'b0;
    if (rst) begin
      pend <= 1'b0;
    end else if (bus_req_valid && tick && !pend) begin
      pend <= 1'b1; wait_cnt <= 2;
      nops <= nops + 1;
      last_op <= bus_req_op; last_byte <= bus_req_byte;
      if (bus_req_op == 2'd3) nend <= nend + 1;
      case (bus_req_op)
        2'd0: bus_rsp_ack <= (bus_req_byte[7:1] == SLAVE);
        2'd1: bus_rsp_ack <= (bus_req_byte != 8'hEE);
        2'd2: begin
          bus_rsp_ack <= !recv_fail;
          bus_rsp_byte <= recv_fail ? 8'h5A : rcnt;
          if (!recv_fail) rcnt <= rcnt + 8'd1;
        end
        default: bus_rsp_ack <= 1'b1;
      endcase
    end else if (pend) begin
      if (wait_cnt == 0) begin
        bus_rsp_valid <= 1'b1; pend <= 1'b0;
      end else wait_cnt <= wait_cnt - 1;
    end
  end

  int errors = 0, checks = 0;
  logic stalled = 1'b0;
  logic finished = 1'b0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    while (!cpu_ready) @(negedge clk);
  endtask

  task automatic cpu_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    while (!cpu_ready) @(negedge clk);
    @(negedge clk);
    cpu_sel = 1'b0; cpu_we = 1'b0;
    stalled = !cpu_ready;
    wait_idle();
  endtask

  task automatic cpu_read(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    while (!cpu_ready) @(negedge clk);
    @(negedge clk);
    d = cpu_rdata;
    cpu_sel = 1'b0;
    wait_idle();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int n0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    cpu_read(A_STA, v); chk("R1 status", v, 8'h81);
    cpu_read(A_CTL, v); chk("R1 control", v, 8'h00);
    cpu_read(A_DAT, v); chk("R1 data", v, 8'h00);
    cpu_read(A_FLT, v); chk("R1 filter", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R2: unmapped offsets
    cpu_read(5'h18, v); chk("R2 offset 0x18", v, 8'h00);
    cpu_read(5'h02, v); chk("R2 offset 0x02", v, 8'h00);

    // R3: mask sweep over all byte values
    for (int i = 0; i < 256; i++) begin
      cpu_write(A_OWN, 8'(i)); cpu_read(A_OWN, v); chk("R3 own", v, 8'(i) & 8'hFE);
      cpu_write(A_DIV, 8'(i)); cpu_read(A_DIV, v); chk("R3 div", v, 8'(i) & 8'h3F);
      cpu_write(A_FLT, 8'(i)); cpu_read(A_FLT, v); chk("R3 filter", v, 8'(i));
    end
    cpu_write(A_STA, 8'hFF); cpu_read(A_STA, v); chk("R3 status", v, 8'hED);
    cpu_write(A_CTL, 8'h7F); cpu_read(A_CTL, v); chk("R3 control", v, 8'h7C);
    cpu_write(A_CTL, 8'h00);
    cpu_write(A_STA, 8'h00);

    // R4: data write while disabled
    n0 = nops;
    cpu_write(A_DAT, 8'h12); cpu_read(A_DAT, v); chk("R4 data kept", v, 8'h00);
    chk("R4 no bus op", 8'(nops - n0), 8'h00);
    cpu_write(A_OWN, 8'h42);

    // R5: master sets bus busy
    cpu_write(A_CTL, 8'hF0);
    cpu_read(A_STA, v); chk("R5 busy set", v, 8'h20);

    // R6/R7/R9/R13: address phase acknowledged
    cpu_write(A_DAT, 8'hA0);
    chk("R13 stall", {7'd0, stalled}, 8'h01);
    chk("R6 start op", {6'd0, last_op}, 8'h00);
    chk("R6 start byte", last_byte, 8'hA0);
    cpu_read(A_STA, v); chk("R7 ack status", v, 8'hA2);
    chk("R9 irq high", {7'd0, irq}, 8'h01);
    cpu_write(A_STA, 8'h20);
    chk("R9 irq cleared", {7'd0, irq}, 8'h00);

    // R6/R7: data byte acknowledged
    cpu_write(A_DAT, 8'h11);
    chk("R6 send op", {6'd0, last_op}, 8'h01);
    chk("R6 send byte", last_byte, 8'h11);
    cpu_read(A_STA, v); chk("R7 send ack status", v, 8'hA2);

    // R8: data byte refused
    cpu_write(A_STA, 8'h20);
    cpu_write(A_DAT, 8'hEE);
    cpu_read(A_STA, v); chk("R8 nack status", v, 8'h21);
    chk("R8 end issued", 8'(nend), 8'h01);
    chk("R8 last op end", {6'd0, last_op}, 8'h03);
    chk("R8 irq low", {7'd0, irq}, 8'h00);

    // R10: repeated start
    cpu_write(A_CTL, 8'hF4);
    chk("R10 end issued", 8'(nend), 8'h02);
    cpu_read(A_CTL, v); chk("R10 bit2 cleared", v, 8'hF0);
    cpu_write(A_DAT, 8'hA1);
    chk("R10 restart op", {6'd0, last_op}, 8'h00);
    chk("R10 restart byte", last_byte, 8'hA1);
    cpu_read(A_STA, v); chk("R10 status", v, 8'hA2);

    // R11: master receive
    cpu_write(A_STA, 8'h20);
    cpu_write(A_CTL, 8'hE0);
    cpu_read(A_DAT, v); chk("R11 old byte", v, 8'hA1);
    chk("R11 fetch op", {6'd0, last_op}, 8'h02);
    cpu_read(A_STA, v); chk("R11 fetch status", v, 8'hA2);
    cpu_read(A_DAT, v); chk("R11 first byte", v, 8'h30);
    cpu_write(A_STA, 8'h20);
    recv_fail = 1'b1;
    cpu_read(A_DAT, v); chk("R11 second byte", v, 8'h31);
    recv_fail = 1'b0;
    cpu_read(A_STA, v); chk("R11 failed fetch status", v, 8'h20);
    cpu_read(A_DAT, v); chk("R11 failed fetch byte", v, 8'hFF);

    // R5: master cleared closes the open transfer
    cpu_write(A_CTL, 8'hC0);
    chk("R5 end on master clear", 8'(nend), 8'h03);
    cpu_read(A_STA, v); chk("R5 busy cleared", v, 8'h82);
    chk("R9 irq with flag", {7'd0, irq}, 8'h01);
    n0 = nops;
    cpu_read(A_DAT, v); chk("R11 slave read byte", v, 8'h32);
    chk("R11 no fetch without master", 8'(nops - n0), 8'h00);

    // R7: address refused, transfer stays closed
    cpu_write(A_STA, 8'h00);
    cpu_write(A_CTL, 8'hB0);
    cpu_write(A_DAT, 8'h22);
    cpu_read(A_STA, v); chk("R7 address nack", v, 8'h21);
    cpu_write(A_DAT, 8'hA0);
    chk("R7 still start", {6'd0, last_op}, 8'h00);
    cpu_read(A_STA, v); chk("R7 retry ack", v, 8'hA2);
    chk("R9 irq gated by enable bit 6", {7'd0, irq}, 8'h00);

    // R12: soft reset
    cpu_write(A_DIV, 8'h15);
    cpu_write(A_CTL, 8'h00);
    cpu_read(A_OWN, v); chk("R12 own kept", v, 8'h42);
    cpu_read(A_STA, v); chk("R12 status", v, 8'h81);
    cpu_read(A_CTL, v); chk("R12 control", v, 8'h00);
    cpu_read(A_DIV, v); chk("R12 divider", v, 8'h00);
    cpu_read(A_DAT, v); chk("R12 data", v, 8'h00);
    chk("R12 irq", {7'd0, irq}, 8'h00);
    n0 = nops;
    cpu_write(A_DAT, 8'h55);
    cpu_read(A_DAT, v); chk("R4 ignored after soft reset", v, 8'h00);
    chk("R4 no op after soft reset", 8'(nops - n0), 8'h00);

    finish_run();
  end
endmodule